// File: doc/BRIEF.md
# Single-Bus Processor Datapath

This block is the register side of a simple processor in which every transfer crosses one shared internal bus. An external sequencer supplies a control word every cycle. In that word, one bit selects the single source that drives the bus, and a vector of load bits names the registers that capture the bus value on the next rising edge. The datapath holds a small general register file, a program counter, an instruction register, a memory address register, a memory data register, an operand latch and a result latch.

The arithmetic unit always takes its first operand from the operand latch and its second operand from the bus. Its result enters the result latch only when that latch's load bit is set, and a negative flag is captured at the same edge. Memory is reached through the address and data registers. A read or write strobe raises a request toward memory, and the request stays up until memory answers with a function-complete pulse. While the data register waits on memory, a stall output tells the sequencer to hold its current step.

A typical read takes three steps: load the address together with the read strobe, wait with memory capture enabled, then move the data register to its destination. A write also takes three steps: load the address, load the data together with the write strobe, then drive the memory data lines while waiting for completion. Incrementing the program counter uses the adder with the carry-in set.

Top module: `sbus_datapath`

## Requirements
- R1: After reset, every register (general registers, program counter, instruction, address, data, operand and result latches) and the negative flag are zero, and no memory request is raised.
- R2: At most one bit of `drv_en` is set in a cycle. `bus_o` equals the selected source, and it is zero when no bit is set. With the default of 4 registers, bits 0 to 3 select general registers 0 to 3, bit 4 the program counter, bit 5 the data register and bit 6 the result latch.
- R3: Each register whose `ld_en` bit is set captures `bus_o` at the rising edge, and every other register keeps its value. With the defaults, bits 0 to 3 are general registers 0 to 3, bit 4 the program counter, bit 5 the instruction register, bit 6 the address register, bit 7 the data register and bit 8 the operand latch.
- R4: With `z_ld` set, the result latch captures f(Y, bus). The function codes are 0 = Y+bus+cin, 1 = Y-bus, 2 = AND, 3 = OR, 4 = bus, and 5 = XOR. Any other code gives zero. Without `z_ld`, the result latch holds.
- R5: The negative flag takes the top bit of the new result at each edge where `z_ld` is set, and holds otherwise.
- R6: The data register captures `mem_rdata` at an edge where `mdr_from_mem` and `mem_mfc` are both high. This capture has priority over its bus load. With `mdr_from_mem` high and `mem_mfc` low, it keeps its value unless its bus load bit is set.
- R7: `mem_wait` is high exactly when `mdr_from_mem` or `mdr_to_mem` is set and `mem_mfc` is low.
- R8: `mem_rd` (`mem_wr`) rises at the edge after `rd_strobe` (`wr_strobe`) and falls at the edge where `mem_mfc` is seen high, unless a new strobe arrives in that same cycle.
- R9: `mem_wdata` equals the data register while `mdr_to_mem` is set, and is zero otherwise.
- R10: `mem_addr` shows the address register, which changes only at an edge where its load bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| drv_en | input | NREG+3 | One-hot bus source select |
| ld_en | input | NREG+5 | Bus load enables |
| z_ld | input | 1 | Capture the arithmetic result and the negative flag |
| alu_op | input | 4 | Arithmetic function code |
| alu_cin | input | 1 | Carry-in for the add function |
| rd_strobe | input | 1 | Start a memory read |
| wr_strobe | input | 1 | Start a memory write |
| mdr_from_mem | input | 1 | Data register takes memory data when completion arrives |
| mdr_to_mem | input | 1 | Data register drives the memory data lines |
| mem_rdata | input | W | Memory read data |
| mem_mfc | input | 1 | Memory function complete |
| bus_o | output | W | Internal bus value |
| pc_o | output | W | Program counter |
| ir_o | output | W | Instruction register |
| n_flag | output | 1 | Negative flag |
| mem_addr | output | W | Memory address (address register) |
| mem_wdata | output | W | Memory write data |
| mem_rd | output | 1 | Pending read request |
| mem_wr | output | 1 | Pending write request |
| mem_wait | output | 1 | Stall: waiting on memory completion |

## Verification
The bench loads operands through real memory reads with latencies of zero to two cycles. A design that sampled memory data before completion, or that cleared the request early, would therefore load stale values into the registers. It sweeps every arithmetic code, including carry-in, wraparound, a negative subtract and an unused code. A wrong operand order, a missed carry-in or a negative flag that is not latched would show up as wrong values on the bus. It also checks three more cases. The first is the data register capture when the bus load and the memory capture collide; a design that gave the bus priority would keep the bus value. The second is a write followed by a read back from the same address; a design that moved the address register without a load, or drove write data at the wrong time, would return a different word. The third is that an undriven bus reads as zero, which the program counter increment relies on.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
    typedef enum logic [3:0] {
        ALU_ADD  = 4'd0,
        ALU_SUB  = 4'd1,
        ALU_AND  = 4'd2,
        ALU_OR   = 4'd3,
        ALU_PASS = 4'd4,
        ALU_XOR  = 4'd5
    } alu_op_e;
endpackage

// File: rtl/sbus_alu.sv
module sbus_alu
    import sbus_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] y_i,
    input  logic [W-1:0] b_i,
    input  logic [3:0]   op_i,
    input  logic         cin_i,
    output logic [W-1:0] res_o
);
    always_comb begin
        unique case (op_i)
            ALU_ADD:  res_o = y_i + b_i + {{(W-1){1'b0}}, cin_i};
            ALU_SUB:  res_o = y_i - b_i;
            ALU_AND:  res_o = y_i & b_i;
            ALU_OR:   res_o = y_i | b_i;
            ALU_PASS: res_o = b_i;
            ALU_XOR:  res_o = y_i ^ b_i;
            default:  res_o = '0;
        endcase
    end
endmodule

// File: rtl/sbus_bus_mux.sv
module sbus_bus_mux #(
    parameter int W    = 16,
    parameter int NSRC = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NSRC-1:0]         en_i,
    input  logic [NSRC-1:0][W-1:0]  src_i,
    output logic [W-1:0]            bus_o
);
    // AND-OR merge stands in for tri-state drivers: a disabled source adds nothing
    always_comb begin
        bus_o = '0;
        for (int i = 0; i < NSRC; i++) begin
            bus_o = bus_o | (src_i[i] & {W{en_i[i]}});
        end
    end

    p_single_driver_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(en_i))
        else $error("more than one bus source enabled");
endmodule

// File: rtl/sbus_regfile.sv
module sbus_regfile #(
    parameter int W    = 16,
    parameter int NREG = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [W-1:0]            bus_i,
    input  logic [NREG-1:0]         ld_i,
    output logic [NREG-1:0][W-1:0]  q_o
);
    logic [NREG-1:0][W-1:0] regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        for (int i = 0; i < NREG; i++) begin
            if (ld_i[i]) regs_d[i] = bus_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign q_o = regs_q;

    for (genvar g = 0; g < NREG; g++) begin : g_hold
        p_reg_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !ld_i[g] |=> $stable(regs_q[g]));
    end
endmodule

// File: rtl/sbus_datapath.sv
module sbus_datapath #(
    parameter int W    = 16,
    parameter int NREG = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NREG+2:0]   drv_en,
    input  logic [NREG+4:0]   ld_en,
    input  logic              z_ld,
    input  logic [3:0]        alu_op,
    input  logic              alu_cin,
    input  logic              rd_strobe,
    input  logic              wr_strobe,
    input  logic              mdr_from_mem,
    input  logic              mdr_to_mem,
    input  logic [W-1:0]      mem_rdata,
    input  logic              mem_mfc,
    output logic [W-1:0]      bus_o,
    output logic [W-1:0]      pc_o,
    output logic [W-1:0]      ir_o,
    output logic              n_flag,
    output logic [W-1:0]      mem_addr,
    output logic [W-1:0]      mem_wdata,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              mem_wait
);
    localparam int NSRC  = NREG + 3;
    localparam int S_PC  = NREG;
    localparam int S_MDR = NREG + 1;
    localparam int S_Z   = NREG + 2;
    localparam int L_PC  = NREG;
    localparam int L_IR  = NREG + 1;
    localparam int L_MAR = NREG + 2;
    localparam int L_MDR = NREG + 3;
    localparam int L_Y   = NREG + 4;

    typedef struct packed {
        logic [W-1:0] pc;
        logic [W-1:0] ir;
        logic [W-1:0] mar;
        logic [W-1:0] mdr;
        logic [W-1:0] y;
        logic [W-1:0] z;
        logic         n;
        logic         rd;
        logic         wr;
    } state_t;

    state_t state_d, state_q;

    logic [NREG-1:0][W-1:0] gpr;
    logic [NSRC-1:0][W-1:0] sources;
    logic [W-1:0]           bus;
    logic [W-1:0]           alu_res;

    sbus_regfile #(.W(W), .NREG(NREG)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .bus_i (bus),
        .ld_i  (ld_en[NREG-1:0]),
        .q_o   (gpr)
    );

    always_comb begin
        for (int i = 0; i < NREG; i++) sources[i] = gpr[i];
        sources[S_PC]  = state_q.pc;
        sources[S_MDR] = state_q.mdr;
        sources[S_Z]   = state_q.z;
    end

    sbus_bus_mux #(.W(W), .NSRC(NSRC)) u_bus (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (drv_en),
        .src_i (sources),
        .bus_o (bus)
    );

    sbus_alu #(.W(W)) u_alu (
        .y_i   (state_q.y),
        .b_i   (bus),
        .op_i  (alu_op),
        .cin_i (alu_cin),
        .res_o (alu_res)
    );

    always_comb begin
        state_d = state_q;
        if (ld_en[L_PC])  state_d.pc  = bus;
        if (ld_en[L_IR])  state_d.ir  = bus;
        if (ld_en[L_MAR]) state_d.mar = bus;
        if (ld_en[L_Y])   state_d.y   = bus;
        if (mdr_from_mem && mem_mfc) state_d.mdr = mem_rdata;
        else if (ld_en[L_MDR])       state_d.mdr = bus;
        if (z_ld) begin
            state_d.z = alu_res;
            state_d.n = alu_res[W-1];
        end
        if (rd_strobe)    state_d.rd = 1'b1;
        else if (mem_mfc) state_d.rd = 1'b0;
        if (wr_strobe)    state_d.wr = 1'b1;
        else if (mem_mfc) state_d.wr = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign bus_o     = bus;
    assign pc_o      = state_q.pc;
    assign ir_o      = state_q.ir;
    assign n_flag    = state_q.n;
    assign mem_addr  = state_q.mar;
    assign mem_wdata = mdr_to_mem ? state_q.mdr : '0;
    assign mem_rd    = state_q.rd;
    assign mem_wr    = state_q.wr;
    assign mem_wait  = (mdr_from_mem || mdr_to_mem) && !mem_mfc;

    p_z_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !z_ld |=> $stable(state_q.z));
    p_n_track_r5: assert property (@(posedge clk) disable iff (!rst_n)
        z_ld |=> n_flag == state_q.z[W-1]);
    p_mdr_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mdr_from_mem && mem_mfc) |=> state_q.mdr == $past(mem_rdata));
    p_rd_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_mfc && !rd_strobe) |=> !mem_rd);
    p_wr_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_mfc && !wr_strobe) |=> !mem_wr);
    p_mar_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_en[L_MAR] |=> $stable(mem_addr));
endmodule

// File: tb/sbus_datapath_test.sv
module sbus_datapath_test;
    localparam int W = 16;
    localparam int NREG = 4;
    localparam int S_PC = 4, S_MDR = 5, S_Z = 6;
    localparam int L_PC = 4, L_IR = 5, L_MAR = 6, L_MDR = 7, L_Y = 8;

    typedef struct packed {
        logic [3:0]  op;
        logic        cin;
        logic [15:0] a;
        logic [15:0] b;
        logic [15:0] exp;
        logic        n;
    } vec_t;

    localparam vec_t VEC [10] = '{
        '{4'd0, 1'b0, 16'h1234, 16'h0111, 16'h1345, 1'b0},
        '{4'd0, 1'b1, 16'h00FF, 16'h0001, 16'h0101, 1'b0},
        '{4'd0, 1'b0, 16'hFFFF, 16'h0002, 16'h0001, 1'b0},
        '{4'd1, 1'b0, 16'h0005, 16'h0003, 16'h0002, 1'b0},
        '{4'd1, 1'b0, 16'h0003, 16'h0005, 16'hFFFE, 1'b1},
        '{4'd2, 1'b0, 16'hF0F0, 16'h3C3C, 16'h3030, 1'b0},
        '{4'd3, 1'b0, 16'hF000, 16'h000F, 16'hF00F, 1'b1},
        '{4'd4, 1'b0, 16'h1111, 16'h8421, 16'h8421, 1'b1},
        '{4'd5, 1'b0, 16'hFF00, 16'h0FF0, 16'hF0F0, 1'b1},
        '{4'd7, 1'b1, 16'h1234, 16'h4321, 16'h0000, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [6:0]  drv_en = '0;
    logic [8:0]  ld_en = '0;
    logic        z_ld = 1'b0;
    logic [3:0]  alu_op = '0;
    logic        alu_cin = 1'b0;
    logic        rd_strobe = 1'b0, wr_strobe = 1'b0;
    logic        mdr_from_mem = 1'b0, mdr_to_mem = 1'b0;
    logic [W-1:0] mem_rdata = '0;
    logic        mem_mfc = 1'b0;
    logic [W-1:0] bus_o, pc_o, ir_o, mem_addr, mem_wdata;
    logic        n_flag, mem_rd, mem_wr, mem_wait;

    logic [W-1:0] mem [16];
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sbus_datapath #(.W(W), .NREG(NREG)) uut (
        .clk(clk), .rst_n(rst_n), .drv_en(drv_en), .ld_en(ld_en), .z_ld(z_ld),
        .alu_op(alu_op), .alu_cin(alu_cin), .rd_strobe(rd_strobe),
        .wr_strobe(wr_strobe), .mdr_from_mem(mdr_from_mem), .mdr_to_mem(mdr_to_mem),
        .mem_rdata(mem_rdata), .mem_mfc(mem_mfc), .bus_o(bus_o), .pc_o(pc_o),
        .ir_o(ir_o), .n_flag(n_flag), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wait(mem_wait)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic clear();
        drv_en = '0; ld_en = '0; z_ld = 1'b0; alu_op = '0; alu_cin = 1'b0;
        rd_strobe = 1'b0; wr_strobe = 1'b0; mdr_from_mem = 1'b0;
        mdr_to_mem = 1'b0; mem_mfc = 1'b0;
    endtask

    task automatic xfer(input int src, input logic [8:0] ld);
        drv_en = (src >= 0) ? 7'(1 << src) : '0;
        ld_en = ld;
        tick();
        clear();
    endtask

    task automatic peek(input int src, output logic [W-1:0] v);
        drv_en = 7'(1 << src);
        #1;
        v = bus_o;
        drv_en = '0;
    endtask

    // memory wait step of a read: R6, R7, R8
    task automatic read_wait(input int lat);
        mdr_from_mem = 1'b1;
        mem_rdata = mem[mem_addr[3:0]];
        for (int k = 0; k < lat; k++) begin
            #1;
            chk("R7 wait high", mem_wait, 1);
            tick();
        end
        mem_mfc = 1'b1;
        #1;
        chk("R7 wait low on mfc", mem_wait, 0);
        tick();
        clear();
        chk("R8 rd dropped", mem_rd, 0);
    endtask

    task automatic load_reg(input int r, input logic [W-1:0] v, input int lat);
        mem[mem_addr[3:0]] = v;
        rd_strobe = 1'b1;
        tick();
        clear();
        chk("R8 rd raised", mem_rd, 1);
        read_wait(lat);
        xfer(S_MDR, 9'(1 << r));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: got hang expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] v;
        for (int i = 0; i < 16; i++) mem[i] = '0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        for (int s = 0; s < 7; s++) begin
            peek(s, v);
            chk("R1 source zero", v, 0);
        end
        chk("R1 pc", pc_o, 0);
        chk("R1 ir", ir_o, 0);
        chk("R1 mar", mem_addr, 0);
        chk("R1 n", n_flag, 0);
        chk("R1 rd", mem_rd, 0);
        chk("R1 wr", mem_wr, 0);
        #1;
        chk("R2 idle bus zero", bus_o, 0);

        // R4/R5: table of ALU vectors
        for (int i = 0; i < 10; i++) begin
            load_reg(0, VEC[i].a, i % 3);
            load_reg(1, VEC[i].b, (i + 1) % 3);
            xfer(0, 9'(1 << L_Y));
            alu_op = VEC[i].op; alu_cin = VEC[i].cin; z_ld = 1'b1;
            drv_en = 7'(1 << 1);
            tick();
            clear();
            peek(S_Z, v);
            chk("R4 alu result", v, VEC[i].exp);
            chk("R5 negative flag", n_flag, VEC[i].n);
        end

        // R4 Z holds without z_ld; R5 n holds
        peek(S_Z, v);
        alu_op = 4'd0; drv_en = 7'(1 << 0);
        tick(); clear();
        peek(S_Z, v);
        chk("R4 z hold", v, 16'h0000);
        chk("R5 n hold", n_flag, 0);

        // PC increment: undriven bus into Y gives zero (R2), then PC+1 twice (R4)
        xfer(-1, 9'(1 << L_Y));
        for (int k = 1; k <= 2; k++) begin
            alu_op = 4'd0; alu_cin = 1'b1; z_ld = 1'b1; drv_en = 7'(1 << S_PC);
            tick(); clear();
            xfer(S_Z, 9'(1 << L_PC));
            chk("R4 pc increment", pc_o, k);
        end

        // R3: multi-destination load and hold of others
        load_reg(2, 16'hA5C3, 1);
        xfer(2, 9'((1 << 3) | (1 << L_IR)));
        chk("R3 ir load", ir_o, 16'hA5C3);
        peek(3, v);
        chk("R3 second dest", v, 16'hA5C3);
        peek(0, v);
        chk("R3 r0 held", v, VEC[9].a);

        // R6: memory capture beats bus load; no mfc keeps MDR
        mem[mem_addr[3:0]] = 16'h7E57;
        mdr_from_mem = 1'b1; mem_rdata = 16'h7E57; mem_mfc = 1'b1;
        drv_en = 7'(1 << 2); ld_en = 9'(1 << L_MDR);
        tick(); clear();
        peek(S_MDR, v);
        chk("R6 mem priority", v, 16'h7E57);
        mdr_from_mem = 1'b1; mem_rdata = 16'h1111; mem_mfc = 1'b0;
        tick(); clear();
        peek(S_MDR, v);
        chk("R6 no mfc hold", v, 16'h7E57);

        // R9/R10/R8: write to address 5, read back
        load_reg(0, 16'h0005, 0);
        load_reg(1, 16'hBEEF, 2);
        chk("R9 wdata idle zero", mem_wdata, 0);
        xfer(0, 9'(1 << L_MAR));
        chk("R10 mar loaded", mem_addr, 16'h0005);
        drv_en = 7'(1 << 1); ld_en = 9'(1 << L_MDR); wr_strobe = 1'b1;
        tick(); clear();
        chk("R8 wr raised", mem_wr, 1);
        chk("R10 mar held", mem_addr, 16'h0005);
        mdr_to_mem = 1'b1;
        #1;
        chk("R9 wdata driven", mem_wdata, 16'hBEEF);
        chk("R7 write wait", mem_wait, 1);
        tick();
        mem_mfc = 1'b1;
        #1;
        mem[mem_addr[3:0]] = mem_wdata;
        tick(); clear();
        chk("R8 wr dropped", mem_wr, 0);
        rd_strobe = 1'b1; tick(); clear();
        read_wait(1);
        xfer(S_MDR, 9'(1 << 2));
        peek(2, v);
        chk("R10 readback", v, 16'hBEEF);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule